// File: doc/BRIEF.md
# Software Watchdog Timer Unit

This block is a down-counting supervision timer running on the system clock. Software sets an expiry period, chooses what the timer does on expiry, and then turns counting on. After that, software has to write a fixed key value to a service register at regular intervals. Each such write puts the period back into the live counter. If software stops doing this, for example because it has hung, the counter reaches zero and the block raises the chosen event. The event is a held chip reset request, a one-cycle non-maskable interrupt pulse, a one-cycle general interrupt pulse, or nothing at all.

A reset-cause flag records that the watchdog requested a reset. The flag is cleared only by power-on reset or by a write-one-to-clear. The ordinary system reset, which the request itself brings about, leaves it alone. Software can therefore read the flag after start-up to learn why the chip restarted. The counter is held by a state machine with four states. IDLE means disabled. RUN means counting. HOLD means the reset request is being driven. SPENT means expired and waiting.

The transitions are as follows:
- IDLE to RUN when enabled.
- RUN to IDLE when disabled.
- RUN to HOLD on expiry with the reset action.
- RUN to SPENT on expiry with any other action.
- HOLD to SPENT after the hold time.
- SPENT to RUN on a valid key write.
- SPENT to IDLE when disabled.

Top module: `wdog_unit`

## Requirements
- R1: After power-on reset, all event outputs are low. The control register reads 0: action 0, disabled, flag clear. The period register and the live count both read all ones.
- R2: There are four word addresses. Address 0 is control: bits [1:0] action, bit 4 enable, bit 8 reset-cause flag. Address 1 is the period, and writing it also loads the live count. Address 2 is the service key register, which reads 0. Address 3 is the live count, which is read-only.
- R3: In RUN the live count drops by one per clock until it reaches zero. The first decrement happens two edges after the write that enables the timer.
- R4: A write of 32'h5AA5_C33C to address 2 copies the period into the live count. Any other value has no effect. While in HOLD, even the key is ignored.
- R5: With action 0, expiry happens on the edge where the timer is in RUN, enabled, and reading zero. From the next cycle, the reset request is high for exactly HOLD_CYCLES (default 16) cycles.
- R6: With action 1 the non-maskable interrupt pulses for one cycle on expiry. With action 2 the general interrupt pulses for one cycle. Action 3 raises nothing. At most one event output is high at a time.
- R7: The reset-cause flag is set on a reset-action expiry. It survives system reset. It is cleared by power-on reset or by writing 1 to control bit 8.
- R8: While disabled, the live count holds its value and no event is raised.
- R9: After an expiry the count stays at zero in SPENT with no further events. A key write then restarts counting from the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; spares the reset-cause flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req_o | output | 1 | Held chip reset request |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| irq_o | output | 1 | General interrupt pulse |

## Verification
The assertions take for granted that reset is applied before any bus activity. They also assume that the bus carries at most one write per cycle, with stable address and data around the edge. Power-on and system reset are assumed to be held across at least one clock edge.

The stimulus changes bus inputs only at the falling edge and keeps the write strobe to a single cycle per access. It asserts either reset for two full cycles. Periods are kept short so that every expiry path is reached within the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SPENT = 2'd3
    } wd_state_e;

    typedef enum logic [1:0] {
        ACT_RESET = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_NONE  = 2'd3
    } wd_action_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LOAD  = 2'd1;
    localparam logic [1:0] ADDR_KICK  = 2'd2;
    localparam logic [1:0] ADDR_COUNT = 2'd3;

    localparam int CTRL_EN_BIT     = 4;
    localparam int CTRL_STICKY_BIT = 8;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] KICK_KEY  = 32'h5AA5_C33C,
    parameter logic [31:0] INIT_LOAD = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic             sticky_set_i,
    output logic [WIDTH-1:0] rdata_o,
    output wd_action_e       action_o,
    output logic             en_o,
    output logic [WIDTH-1:0] load_o,
    output logic             load_wr_o,
    output logic             kick_o,
    output logic             sticky_o
);

    localparam logic [WIDTH-1:0] KEY_W  = KICK_KEY[WIDTH-1:0];
    localparam logic [WIDTH-1:0] INIT_W = INIT_LOAD[WIDTH-1:0];

    logic ctrl_wr;
    logic sticky_clr;

    assign ctrl_wr    = we_i && (addr_i == ADDR_CTRL);
    assign load_wr_o  = we_i && (addr_i == ADDR_LOAD);
    assign kick_o     = we_i && (addr_i == ADDR_KICK) && (wdata_i == KEY_W);
    assign sticky_clr = ctrl_wr && wdata_i[CTRL_STICKY_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            action_o <= ACT_RESET;
            en_o     <= 1'b0;
            load_o   <= INIT_W;
        end else begin
            if (ctrl_wr) begin
                action_o <= wd_action_e'(wdata_i[1:0]);
                en_o     <= wdata_i[CTRL_EN_BIT];
            end
            if (load_wr_o) begin
                load_o <= wdata_i;
            end
        end
    end

    // reset-cause flag lives on the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sticky_o <= 1'b0;
        end else if (sticky_set_i) begin
            sticky_o <= 1'b1;
        end else if (sticky_clr) begin
            sticky_o <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rdata_o[1:0]            = action_o;
                rdata_o[CTRL_EN_BIT]     = en_o;
                rdata_o[CTRL_STICKY_BIT] = sticky_o;
            end
            ADDR_LOAD:  rdata_o = load_o;
            ADDR_KICK:  rdata_o = '0;
            ADDR_COUNT: rdata_o = cnt_i;
            default:    rdata_o = '0;
        endcase
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!por_n)
        sticky_set_i |=> sticky_o); // R7
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (sticky_o && !sticky_clr) |=> sticky_o); // R7

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] INIT_LOAD = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             reload_i,
    input  logic [WIDTH-1:0] reload_val_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             zero_o
);

    localparam logic [WIDTH-1:0] INIT_W = INIT_LOAD[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE_W  = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= INIT_W;
        end else if (load_wr_i) begin
            cnt_o <= load_val_i;
        end else if (reload_i) begin
            cnt_o <= reload_val_i;
        end else if (dec_i) begin
            cnt_o <= cnt_o - ONE_W;
        end
    end

    assign zero_o = (cnt_o == '0);

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_wr_i && !reload_i) |=> (cnt_o == $past(cnt_o) - ONE_W)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_wr_i && !reload_i) |=> zero_o); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !load_wr_i && !reload_i) |=> $stable(cnt_o)); // R8

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       zero_i,
    input  logic       kick_i,
    input  logic       load_wr_i,
    input  wd_action_e action_i,
    output wd_state_e  state_o,
    output logic       dec_o,
    output logic       reload_ok_o,
    output logic       sticky_set_o,
    output logic       rst_req_o,
    output logic       nmi_o,
    output logic       irq_o
);

    localparam int HW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    wd_state_e      state_q, state_d;
    logic [HW-1:0]  hold_q;
    logic           expire;

    assign state_o     = state_q;
    assign reload_ok_o = kick_i && (state_q != ST_HOLD);
    assign dec_o       = (state_q == ST_RUN) && en_i && !zero_i;
    assign expire      = (state_q == ST_RUN) && en_i && zero_i
                         && !reload_ok_o && !load_wr_i;
    assign sticky_set_o = expire && (action_i == ACT_RESET);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (expire) begin
                    state_d = (action_i == ACT_RESET) ? ST_HOLD : ST_SPENT;
                end
            end
            ST_HOLD: begin
                if (hold_q == HOLD_LAST) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (reload_ok_o) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            rst_req_o <= 1'b0;
            nmi_o     <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            hold_q    <= (state_q == ST_HOLD) ? hold_q + 1'b1 : '0;
            rst_req_o <= (state_d == ST_HOLD);
            nmi_o     <= expire && (action_i == ACT_NMI);
            irq_o     <= expire && (action_i == ACT_IRQ);
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_req_o, nmi_o, irq_o}) <= 1); // R6
    AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R6
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(zero_i) && $past(state_q == ST_RUN))); // R5
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !nmi_o && !irq_o && !rst_req_o); // R8

endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
    import wdog_pkg::*;
#(
    parameter int          WIDTH       = 32,
    parameter int          HOLD_CYCLES = 16,
    parameter logic [31:0] KICK_KEY    = 32'h5AA5_C33C,
    parameter logic [31:0] INIT_LOAD   = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req_o,
    output logic        nmi_o,
    output logic        irq_o
);

    logic             core_rst_n;
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] load_val;
    logic [WIDTH-1:0] rdata_w;
    logic             zero;
    logic             load_wr;
    logic             kick;
    logic             reload_ok;
    logic             dec;
    logic             en;
    logic             sticky;
    logic             sticky_set;
    wd_action_e       action;
    wd_state_e        state;

    assign core_rst_n = por_n & sys_rst_n;
    assign bus_rdata  = 32'(rdata_w);

    wdog_regs #(
        .WIDTH    (WIDTH),
        .KICK_KEY (KICK_KEY),
        .INIT_LOAD(INIT_LOAD)
    ) u_regs (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .por_n       (por_n),
        .we_i        (bus_we),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata[WIDTH-1:0]),
        .cnt_i       (cnt),
        .sticky_set_i(sticky_set),
        .rdata_o     (rdata_w),
        .action_o    (action),
        .en_o        (en),
        .load_o      (load_val),
        .load_wr_o   (load_wr),
        .kick_o      (kick),
        .sticky_o    (sticky)
    );

    wdog_count #(
        .WIDTH    (WIDTH),
        .INIT_LOAD(INIT_LOAD)
    ) u_count (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .load_wr_i   (load_wr),
        .load_val_i  (bus_wdata[WIDTH-1:0]),
        .reload_i    (reload_ok),
        .reload_val_i(load_val),
        .dec_i       (dec),
        .cnt_o       (cnt),
        .zero_o      (zero)
    );

    wdog_fsm #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .en_i        (en),
        .zero_i      (zero),
        .kick_i      (kick),
        .load_wr_i   (load_wr),
        .action_i    (action),
        .state_o     (state),
        .dec_o       (dec),
        .reload_ok_o (reload_ok),
        .sticky_set_o(sticky_set),
        .rst_req_o   (rst_req_o),
        .nmi_o       (nmi_o),
        .irq_o       (irq_o)
    );

    AST_HOLD_NO_KICK: assert property (@(posedge clk) disable iff (!core_rst_n)
        (state == ST_HOLD && !load_wr) |=> $stable(cnt)); // R4
    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(rst_req_o) |-> sticky); // R7

endmodule

// File: tb/wdog_unit_tb.sv
module wdog_unit_tb;

    localparam int          HOLD = 16;
    localparam logic [31:0] KEY  = 32'h5AA5_C33C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        rst_req_o, nmi_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ev_nmi = 0, ev_irq = 0, ev_rst = 0;

    always #2 clk = ~clk;

    wdog_unit u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .nmi_o(nmi_o), .irq_o(irq_o)
    );

    // behavioural reference: 0 idle, 1 run, 2 hold, 3 spent
    int          m_st = 0;
    int          m_hc = 0;
    logic [31:0] m_cnt = '1, m_load = '1;
    logic [1:0]  m_act = 2'd0;
    logic        m_en = 1'b0, m_flag = 1'b0;
    logic        m_rst = 1'b0, m_nmi = 1'b0, m_irq = 1'b0;

    always @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            m_st = 0; m_hc = 0; m_cnt = '1; m_load = '1; m_act = 2'd0; m_en = 1'b0;
            m_rst = 1'b0; m_nmi = 1'b0; m_irq = 1'b0;
            if (!por_n) m_flag = 1'b0;
        end else begin
            automatic bit kick = bus_we && bus_addr == 2'd2 && bus_wdata == KEY;
            automatic bit ldw  = bus_we && bus_addr == 2'd1;
            automatic bit cw   = bus_we && bus_addr == 2'd0;
            automatic bit rel  = kick && m_st != 2;
            automatic bit exp  = m_st == 1 && m_en && m_cnt == 0 && !rel && !ldw;
            automatic int nst  = m_st;
            case (m_st)
                0: if (m_en) nst = 1;
                1: if (!m_en) nst = 0; else if (exp) nst = (m_act == 2'd0) ? 2 : 3;
                2: if (m_hc == HOLD - 1) nst = 3;
                default: if (!m_en) nst = 0; else if (rel) nst = 1;
            endcase
            m_nmi = exp && m_act == 2'd1;
            m_irq = exp && m_act == 2'd2;
            m_rst = (nst == 2);
            if (exp && m_act == 2'd0) m_flag = 1'b1;
            else if (cw && bus_wdata[8]) m_flag = 1'b0;
            if (ldw) m_cnt = bus_wdata;
            else if (rel) m_cnt = m_load;
            else if (m_st == 1 && m_en && m_cnt != 0) m_cnt = m_cnt - 1;
            m_hc = (m_st == 2) ? m_hc + 1 : 0;
            m_st = nst;
            if (cw) begin m_act = bus_wdata[1:0]; m_en = bus_wdata[4]; end
            if (ldw) m_load = bus_wdata;
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {23'd0, m_flag, 3'd0, m_en, 2'd0, m_act};
            2'd1:    return m_load;
            2'd2:    return 32'd0;
            default: return m_cnt;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic compare();
        if (por_n && sys_rst_n) begin
            check(rst_req_o == m_rst, "R5 reset request", 32'(rst_req_o), 32'(m_rst));
            check(nmi_o == m_nmi, "R6 nmi", 32'(nmi_o), 32'(m_nmi));
            check(irq_o == m_irq, "R6 irq", 32'(irq_o), 32'(m_irq));
            check(bus_rdata == m_read(bus_addr), "R2/R3 readback", bus_rdata, m_read(bus_addr));
        end
        if (nmi_o) ev_nmi++;
        if (irq_o) ev_irq++;
        if (rst_req_o) ev_rst++;
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 compare();
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    task automatic pulse_reset(input bit por);
        @(negedge clk);
        bus_we = 1'b0;
        if (por) por_n = 1'b0; else sys_rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, actual=%0d expected<100000", cyc);
            summary();
        end
    end

    logic [31:0] tmp;

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk) por_n = 1'b1;
        step(1'b0, 2'd0, 0);
        check(bus_rdata == 32'd0, "R1 ctrl after por", bus_rdata, 32'd0);
        check({rst_req_o, nmi_o, irq_o} == 3'b000, "R1 events low", 32'({rst_req_o, nmi_o, irq_o}), 0);
        step(1'b0, 2'd3, 0);
        check(bus_rdata == 32'hFFFF_FFFF, "R1 count after por", bus_rdata, 32'hFFFF_FFFF);

        // R2/R3 NMI action, serviced then left to expire
        step(1'b1, 2'd1, 32'd10);
        step(1'b0, 2'd3, 0);
        check(bus_rdata == 32'd10, "R2 load writes live count", bus_rdata, 32'd10);
        step(1'b1, 2'd0, 32'h11);
        idle(5, 2'd3);
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 2'd2, KEY);
            idle(6, 2'd3);
        end
        check(ev_nmi == 0, "R4 key service prevents expiry", ev_nmi, 0);
        step(1'b1, 2'd2, 32'h1234_5678);
        step(1'b1, 2'd2, ~KEY);
        step(1'b0, 2'd3, 0);
        check(bus_rdata < 32'd10, "R4 wrong key ignored", bus_rdata, 32'd10);
        idle(20, 2'd3);
        check(ev_nmi == 1, "R6 nmi single pulse", ev_nmi, 1);
        check(bus_rdata == 32'd0, "R9 spent count at zero", bus_rdata, 0);
        idle(10, 2'd3);
        check(ev_nmi == 1, "R9 no repeat event", ev_nmi, 1);
        step(1'b1, 2'd2, KEY);
        step(1'b0, 2'd3, 0);
        check(bus_rdata == 32'd9, "R9 key restarts from period", bus_rdata, 32'd9);
        idle(14, 2'd3);
        check(ev_nmi == 2, "R9 second expiry", ev_nmi, 2);

        // R8 disable mid-count
        step(1'b1, 2'd1, 32'd40);
        step(1'b1, 2'd0, 32'h12);
        idle(8, 2'd3);
        step(1'b1, 2'd0, 32'h02);
        idle(2, 2'd3);
        tmp = bus_rdata;
        idle(30, 2'd3);
        check(bus_rdata == tmp, "R8 count held while disabled", bus_rdata, tmp);
        check(ev_irq == 0, "R8 no event while disabled", ev_irq, 0);

        // R6 general interrupt, then silent action
        step(1'b1, 2'd1, 32'd6);
        step(1'b1, 2'd0, 32'h12);
        idle(15, 2'd3);
        check(ev_irq == 1, "R6 irq single pulse", ev_irq, 1);
        step(1'b1, 2'd0, 32'h03);
        step(1'b1, 2'd1, 32'd4);
        step(1'b1, 2'd0, 32'h13);
        idle(15, 2'd3);
        check(ev_irq == 1 && ev_nmi == 2 && ev_rst == 0, "R6 silent action", ev_irq + ev_nmi + ev_rst, 3);

        // R5/R7 reset action, key ignored during hold
        step(1'b1, 2'd0, 32'h00);
        step(1'b1, 2'd1, 32'd5);
        step(1'b1, 2'd0, 32'h10);
        idle(9, 2'd3);
        step(1'b1, 2'd2, KEY);
        idle(HOLD + 6, 2'd3);
        check(ev_rst == HOLD, "R5 request length", ev_rst, HOLD);
        check(bus_rdata == 32'd0, "R4 key ignored in hold", bus_rdata, 0);
        step(1'b0, 2'd0, 0);
        check(bus_rdata[8] == 1'b1, "R7 flag set", 32'(bus_rdata[8]), 1);
        pulse_reset(1'b0);
        step(1'b0, 2'd0, 0);
        check(bus_rdata == 32'h100, "R7 flag survives system reset", bus_rdata, 32'h100);
        step(1'b1, 2'd0, 32'h100);
        step(1'b0, 2'd0, 0);
        check(bus_rdata == 32'h0, "R7 write one clears flag", bus_rdata, 0);

        // R7 power-on reset clears flag
        step(1'b1, 2'd1, 32'd3);
        step(1'b1, 2'd0, 32'h10);
        idle(HOLD + 10, 2'd0);
        check(bus_rdata[8] == 1'b1, "R7 flag set again", 32'(bus_rdata[8]), 1);
        pulse_reset(1'b1);
        step(1'b0, 2'd0, 0);
        check(bus_rdata == 32'h0, "R7 por clears flag", bus_rdata, 0);
        idle(3, 2'd1);
        summary();
    end

endmodule